// File: doc/BRIEF.md
# Presence-Bit Field Expander

This block takes one compressed configuration word for a single processing element and restores the full fixed-layout instruction from it. The compressed word starts with a header. The header holds one presence flag for each of the nine instruction fields. After the header come only the fields whose flags are set, packed back to back with no gaps. Because absent fields take no space, where each field sits in the packed word depends on which earlier fields were present.

Each field's packed position is found with a running sum of the widths of the earlier present fields. The field is shifted out from that position, masked when it is absent, and placed into its fixed slot of the 41-bit instruction. The block also returns the number of packed bits it used, so that a stream walker can find the start of the next compressed word.

Decoding is combinational. The result is captured in one register stage, so each result appears one cycle after its input is accepted.

Top module: `pfx_expander`

## Requirements
- R1: Header bit i of `in_word` is the presence flag of field i. The fields in order are opcode (0, 8 bits), pred (1, 3), src0 (2, 4), src1 (3, 4), route (4, 4), write (5, 3), waddr (6, 3), raddr (7, 3) and const (8, 9). `out_field_vld[i]` equals header bit i of the accepted word.
- R2: Present fields are packed LSB-first starting at bit 9 of `in_word`, in ascending field order, with no gaps. Each field's LSB comes first.
- R3: In `out_instr`, field i occupies the bits starting at the sum of the widths of fields 0..i-1, LSB-first. That gives opcode [7:0], pred [10:8], src0 [14:11], src1 [18:15], route [22:19], write [25:23], waddr [28:26], raddr [31:29] and const [40:32].
- R4: Every absent field reads as zero in `out_instr`, and its flag is low.
- R5: `out_len` equals 9 plus the sum of the widths of the present fields.
- R6: A header of all zeros gives an all-zero instruction, all flags low and `out_len` = 9.
- R7: A header of all ones gives `out_len` = 50, with every field taken from its packed position.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The results of that input appear in the same cycle.
- R9: Bits of `in_word` at or above position `out_len` have no effect on any output.
- R10: While `in_valid` is low, `out_instr`, `out_field_vld` and `out_len` keep their values and `out_valid` stays low.
- R11: During reset, `out_valid`, `out_instr`, `out_field_vld` and `out_len` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compressed word on `in_word` is to be decoded |
| in_word | input | 50 | Header in bits [8:0], packed present fields from bit 9 |
| out_valid | output | 1 | Registered result is new this cycle |
| out_instr | output | 41 | Expanded instruction in fixed layout |
| out_field_vld | output | 9 | Per-field presence of the expanded instruction |
| out_len | output | 6 | Packed bits consumed, header included |

## Verification
A wrong entry in the running offset chain moves every later present field. The damage therefore shows as corrupted slots from that field upward in `out_instr`, together with a wrong `out_len`, in the cycle right after the input. A stuck presence mask shows as a nonzero absent field or a wrong flag in that same cycle. Loading the output register when `in_valid` is low shows up in the following idle cycle, as a change on an output that should have held its value. Distinct field values and junk-filled tails make shifted or overlapped fields visible at once rather than hidden by zero padding.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int NF    = 9;
  localparam int HDR_W = NF;

  // Width of each field, indexed in packing order.
  function automatic int fld_w(input int idx);
    case (idx)
      0: return 8;
      1: return 3;
      2: return 4;
      3: return 4;
      4: return 4;
      5: return 3;
      6: return 3;
      7: return 3;
      8: return 9;
      default: return 0;
    endcase
  endfunction

  // Start bit of a field in the expanded instruction.
  function automatic int full_ofs(input int idx);
    int acc;
    acc = 0;
    for (int j = 0; j < idx; j++) acc += fld_w(j);
    return acc;
  endfunction

  localparam int INSTR_W = full_ofs(NF);
  localparam int PACK_W  = HDR_W + INSTR_W;
  localparam int LEN_W   = $clog2(PACK_W + 1);

  // Packed length for a given presence mask, header included.
  function automatic logic [LEN_W-1:0] packed_len(input logic [NF-1:0] pres);
    int acc;
    acc = HDR_W;
    for (int j = 0; j < NF; j++) if (pres[j]) acc += fld_w(j);
    return LEN_W'(acc);
  endfunction
endpackage

// File: rtl/pfx_offset_calc.sv
module pfx_offset_calc
  import pfx_pkg::*;
(
  input  logic [NF-1:0]            pres,
  output logic [NF-1:0][LEN_W-1:0] fld_pos,
  output logic [LEN_W-1:0]         total_len
);
  logic [LEN_W-1:0] chain [NF+1];

  assign chain[0] = LEN_W'(HDR_W);

  for (genvar i = 0; i < NF; i++) begin : g_step
    localparam int W = fld_w(i);
    assign chain[i+1] = chain[i] + (pres[i] ? LEN_W'(W) : '0);
    assign fld_pos[i] = chain[i];
  end

  assign total_len = chain[NF];
endmodule

// File: rtl/pfx_field_extract.sv
module pfx_field_extract
  import pfx_pkg::*;
#(
  parameter int IDX = 0,
  localparam int W  = fld_w(IDX)
) (
  input  logic [PACK_W-1:0] word,
  input  logic [LEN_W-1:0]  pos,
  input  logic              present,
  output logic [W-1:0]      value
);
  logic [PACK_W-1:0] shifted;

  assign shifted = word >> pos;
  assign value   = present ? W'(shifted) : '0;
endmodule

// File: rtl/pfx_out_reg.sv
module pfx_out_reg
  import pfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [INSTR_W-1:0] d_instr,
  input  logic [NF-1:0]      d_vld,
  input  logic [LEN_W-1:0]   d_len,
  output logic               q_valid,
  output logic [INSTR_W-1:0] q_instr,
  output logic [NF-1:0]      q_vld,
  output logic [LEN_W-1:0]   q_len
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_instr <= '0;
      q_vld   <= '0;
      q_len   <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_instr <= d_instr;
        q_vld   <= d_vld;
        q_len   <= d_len;
      end
    end
  end

  // Each absent field must leave its slot cleared.
  for (genvar i = 0; i < NF; i++) begin : g_chk
    localparam int W = fld_w(i);
    localparam int O = full_ofs(i);
    assert_absent_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !q_vld[i] |-> q_instr[O +: W] == '0);
  end
endmodule

// File: rtl/pfx_expander.sv
module pfx_expander
  import pfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PACK_W-1:0]  in_word,
  output logic               out_valid,
  output logic [INSTR_W-1:0] out_instr,
  output logic [NF-1:0]      out_field_vld,
  output logic [LEN_W-1:0]   out_len
);
  logic [NF-1:0]            hdr_pres;
  logic [NF-1:0][LEN_W-1:0] fld_pos;
  logic [LEN_W-1:0]         comb_len;
  logic [INSTR_W-1:0]       comb_instr;

  assign hdr_pres = in_word[NF-1:0];

  pfx_offset_calc u_ofs (
    .pres      (hdr_pres),
    .fld_pos   (fld_pos),
    .total_len (comb_len)
  );

  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam int W = fld_w(i);
    localparam int O = full_ofs(i);
    pfx_field_extract #(.IDX(i)) u_ext (
      .word    (in_word),
      .pos     (fld_pos[i]),
      .present (hdr_pres[i]),
      .value   (comb_instr[O +: W])
    );
  end

  pfx_out_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .d_instr (comb_instr),
    .d_vld   (hdr_pres),
    .d_len   (comb_len),
    .q_valid (out_valid),
    .q_instr (out_instr),
    .q_vld   (out_field_vld),
    .q_len   (out_len)
  );

  // Length from the loop form, set against the adder chain.
  assert_len_matches_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len == packed_len(out_field_vld));

  assert_flags_follow_header_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_field_vld == $past(in_word[NF-1:0]));

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_instr) && $stable(out_field_vld)
                 && $stable(out_len));

  assert_empty_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_field_vld == '0) |-> out_instr == '0 && out_len == LEN_W'(HDR_W));

  assert_full_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && &out_field_vld) |-> out_len == LEN_W'(PACK_W));
endmodule

// File: tb/pfx_expander_bench.sv
`timescale 1ns/1ps
module pfx_expander_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [49:0] in_word;
  logic        out_valid;
  logic [40:0] out_instr;
  logic [8:0]  out_field_vld;
  logic [5:0]  out_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pfx_expander u_pfx_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_instr(out_instr),
    .out_field_vld(out_field_vld), .out_len(out_len)
  );

  function automatic int bw(input int i);
    int tab [9] = '{8, 3, 4, 4, 4, 3, 3, 3, 9};
    return tab[i];
  endfunction

  function automatic int bslot(input int i);
    int s = 0;
    for (int k = 0; k < i; k++) s += bw(k);
    return s;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Packs src under pres, optionally fills the tail with junk, drives one
  // word and checks the registered result one cycle later.
  task automatic run_case(input logic [8:0] pres, input logic [40:0] src,
                          input bit junk, input string req);
    logic [49:0] w;
    logic [40:0] exp_instr;
    int pos;
    w = '0;
    exp_instr = '0;
    w[8:0] = pres;
    pos = 9;
    for (int i = 0; i < 9; i++) begin
      if (pres[i]) begin
        for (int b = 0; b < bw(i); b++) begin
          w[pos] = src[bslot(i) + b];
          exp_instr[bslot(i) + b] = src[bslot(i) + b];
          pos++;
        end
      end
    end
    if (junk) for (int k = pos; k < 50; k++) w[k] = 1'($urandom);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = ~w;
    chk({req, " R8 valid"}, 64'(out_valid), 64'd1);
    chk({req, " R3 instr"}, 64'(out_instr), 64'(exp_instr));
    chk({req, " R1 flags"}, 64'(out_field_vld), 64'(pres));
    chk({req, " R5 len"}, 64'(out_len), 64'(pos));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_valid = 1'b1;
    in_word = '1;
    repeat (3) @(negedge clk);
    chk("R11 valid", 64'(out_valid), 0);
    chk("R11 instr", 64'(out_instr), 0);
    chk("R11 flags", 64'(out_field_vld), 0);
    chk("R11 len", 64'(out_len), 0);
    in_valid = 1'b0;
    in_word = '0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_empty;
    run_case(9'h000, 41'h1FF_FFFF_FFFF, 1'b1, "R6 empty");
  endtask

  task automatic t_full;
    run_case(9'h1FF, 41'h15A_C3E1_96B7, 1'b0, "R7 full");
    run_case(9'h1FF, 41'h0A5_3C1E_6948, 1'b0, "R7 full2");
  endtask

  task automatic t_single;
    for (int i = 0; i < 9; i++)
      run_case(9'(1 << i), 41'h1FF_FFFF_FFFF, 1'b1, "R2 single");
  endtask

  task automatic t_patterns;
    run_case(9'h155, 41'h13B_5D7A_2C91, 1'b1, "R2 alt");
    run_case(9'h0AA, 41'h0E6_4B19_F3D2, 1'b1, "R2 alt2");
    run_case(9'h100, 41'h1AB_0000_0000, 1'b1, "R9 const only");
    for (int n = 0; n < 40; n++)
      run_case(9'($urandom), {9'($urandom), 32'($urandom)}, 1'b1, "R9 mixed");
  endtask

  task automatic t_absent_zero;
    // The source carries ones in every slot, so any leak of an absent field shows.
    run_case(9'h0F0, 41'h1FF_FFFF_FFFF, 1'b1, "R4 absent");
    chk("R4 low fields", 64'(out_instr[18:0]), 0);
  endtask

  task automatic t_hold;
    logic [40:0] i0;
    logic [8:0]  v0;
    logic [5:0]  l0;
    run_case(9'h03C, 41'h0F0_F0F0_F0F0, 1'b1, "R10 prep");
    i0 = out_instr; v0 = out_field_vld; l0 = out_len;
    in_word = '1;
    @(negedge clk);
    chk("R10 valid low", 64'(out_valid), 0);
    chk("R10 instr held", 64'(out_instr), 64'(i0));
    chk("R10 flags held", 64'(out_field_vld), 64'(v0));
    chk("R10 len held", 64'(out_len), 64'(l0));
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_word = '0;
    t_reset();
    t_empty();
    t_full();
    t_single();
    t_absent_zero();
    t_patterns();
    t_hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule